// File: doc/BRIEF.md
# Two-Bank Interleaved SRAM Front End

This block sits between a single-port bus and two physically separate 32-bit SRAM arrays. Consecutive words alternate between the arrays: word 0 of the window lives in bank 0, word 1 in bank 1, word 2 in bank 0 again, and so on. The bus presents at most one request per cycle. Each request carries a direction, a byte address, four byte enables and write data. The controller drives exactly one bank for each accepted in-window request and returns read data one cycle later with a valid strobe.

An array cannot serve a read in the cycle right after it has taken a write. The controller watches for a read whose bank matches the bank written in the previous cycle. When it sees one, it holds the read in an internal register and drops `req_ready` for one cycle. The held read goes to the bank in the following cycle. Every other ordering runs back to back, including a write followed by a read of the other bank.

The control is a two-state machine. `ST_FLOW` passes requests straight through to the banks. On a same-bank write-then-read hazard it takes the transition FLOW→STALL. In `ST_STALL` it issues the held read and always takes the transition STALL→FLOW. The window starts at byte address `BASE` (default 0x2000_0000) and spans `ROWS` rows in each bank. Addresses outside the window are not claimed.

Top module: `ilv_sram_ctrl`

## Requirements
- R1: For an in-window address, word index w = (addr - BASE) >> 2 selects bank w[0] (address bit 2 of the offset) and row w >> 1 in that bank. Exactly that bank's enable is raised, and its write strobe equals the request direction.
- R2: A write changes only the byte lanes whose enable bit is set, where enable bit i covers data bits 8i+7 down to 8i. The other lanes of the word keep their old contents.
- R3: If a read targets the bank written in the immediately preceding cycle, `req_ready` is low for exactly one cycle and no bank is enabled in that cycle. The read is then issued in the next cycle, so a bank is never read in the cycle right after it was written.
- R4: A write to one bank followed in the next cycle by a read of the other bank completes with no wait cycle.
- R5: Read-after-read, write-after-write and read-then-write sequences take no wait cycle in either bank.
- R6: `rsp_valid` is high in exactly the cycle after a read was issued to a bank, and `rsp_rdata` then holds the addressed word's current contents.
- R7: A request outside [BASE, BASE + 8*ROWS) enables no bank, keeps `req_ready` high, produces no response and leaves memory contents unchanged.
- R8: During and immediately after reset, `req_ready` is high, `rsp_valid` is low and no bank is enabled.
- R9: At most one bank enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| bk_en | output | 2 | Per-bank access enable |
| bk_we | output | 2 | Per-bank write strobe |
| bk_row | output | 2 x ROW_W | Per-bank row index |
| bk_be | output | 2 x 4 | Per-bank byte enables |
| bk_wdata | output | 2 x 32 | Per-bank write data |
| bk_rdata | input | 2 x 32 | Per-bank registered read data |

## Verification
The hardest situation to reach is a write immediately followed by a read of the same bank. It needs two back-to-back accepted requests whose word indices have equal parity, with no idle or out-of-window cycle between them. The bench sweeps every word of a small 32-word window against offsets of 0 to 3 words and all four direction pairs. Each pair starts from an idle cycle, so every same-bank, other-bank and same-word combination occurs with a known predecessor. The byte-lane sweep also writes and then reads the same word back to back, so partial writes are always read through the stall path.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int NBANK = 2;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;

    typedef enum logic [0:0] {
        ST_FLOW  = 1'b0,
        ST_STALL = 1'b1
    } hz_state_e;
endpackage

// File: rtl/ilv_addr_decode.sv
module ilv_addr_decode #(
    parameter logic [31:0] BASE  = 32'h2000_0000,
    parameter int          ROWS  = 1024,
    parameter int          ROW_W = $clog2(ROWS)
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic             bank,
    output logic [ROW_W-1:0] row
);
    // window size in bytes: two banks of ROWS words each
    localparam logic [31:0] SPAN = 32'(ROWS) * 32'd8;

    logic [31:0] off;

    always_comb begin
        off  = addr - BASE;
        hit  = (off < SPAN);
        bank = off[2];
        row  = off[3 +: ROW_W];
    end
endmodule

// File: rtl/ilv_hazard_fsm.sv
module ilv_hazard_fsm
    import ilv_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             dec_hit,
    input  logic             dec_bank,
    input  logic [ROW_W-1:0] dec_row,
    output logic             req_ready,
    output logic             iss_vld,
    output logic             iss_wr,
    output logic             iss_bank,
    output logic [ROW_W-1:0] iss_row
);
    hz_state_e        st_q, st_d;
    logic             wr_seen_q;
    logic             wr_bank_q;
    logic             hold_bank_q;
    logic [ROW_W-1:0] hold_row_q;
    logic             hazard;

    // read hitting the bank that took a write in the previous cycle
    assign hazard = req_valid && dec_hit && !req_write
                    && wr_seen_q && (dec_bank == wr_bank_q);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FLOW;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q   <= 1'b0;
            wr_bank_q   <= 1'b0;
            hold_bank_q <= 1'b0;
            hold_row_q  <= '0;
        end else begin
            wr_seen_q <= iss_vld && iss_wr;
            wr_bank_q <= iss_bank;
            if (st_q == ST_FLOW && hazard) begin
                hold_bank_q <= dec_bank;
                hold_row_q  <= dec_row;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        req_ready = 1'b1;
        iss_vld   = 1'b0;
        iss_wr    = 1'b0;
        iss_bank  = dec_bank;
        iss_row   = dec_row;
        unique case (st_q)
            ST_FLOW: begin
                if (hazard) begin
                    st_d      = ST_STALL;
                    req_ready = 1'b0;
                end else begin
                    iss_vld = req_valid && dec_hit;
                    iss_wr  = req_write;
                end
            end
            ST_STALL: begin
                st_d     = ST_FLOW;
                iss_vld  = 1'b1;
                iss_wr   = 1'b0;
                iss_bank = hold_bank_q;
                iss_row  = hold_row_q;
            end
            default: st_d = ST_FLOW;
        endcase
    end
endmodule

// File: rtl/ilv_bank_drive.sv
module ilv_bank_drive
    import ilv_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic                             iss_vld,
    input  logic                             iss_wr,
    input  logic                             iss_bank,
    input  logic [ROW_W-1:0]                 iss_row,
    input  logic [BEW-1:0]                   wr_be,
    input  logic [DW-1:0]                    wr_data,
    output logic [NBANK-1:0]                 bk_en,
    output logic [NBANK-1:0]                 bk_we,
    output logic [NBANK-1:0][ROW_W-1:0]      bk_row,
    output logic [NBANK-1:0][BEW-1:0]        bk_be,
    output logic [NBANK-1:0][DW-1:0]         bk_wdata
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic SEL = 1'(b);
        assign bk_en[b]    = iss_vld && (iss_bank == SEL);
        assign bk_we[b]    = bk_en[b] && iss_wr;
        assign bk_row[b]   = iss_row;
        assign bk_be[b]    = iss_wr ? wr_be : '0;
        assign bk_wdata[b] = wr_data;
    end
endmodule

// File: rtl/ilv_rd_return.sv
module ilv_rd_return
    import ilv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_rd,
    input  logic                     iss_bank,
    input  logic [NBANK-1:0][DW-1:0] bk_rdata,
    output logic                     rsp_valid,
    output logic [DW-1:0]            rsp_rdata
);
    logic bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            bank_q    <= 1'b0;
        end else begin
            rsp_valid <= iss_rd;
            if (iss_rd) bank_q <= iss_bank;
        end
    end

    assign rsp_rdata = bk_rdata[bank_q];
endmodule

// File: rtl/ilv_sram_ctrl.sv
module ilv_sram_ctrl
    import ilv_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h2000_0000,
    parameter int          ROWS  = 1024,
    localparam int         ROW_W = $clog2(ROWS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [31:0]                 req_addr,
    input  logic [BEW-1:0]              req_be,
    input  logic [DW-1:0]               req_wdata,
    output logic                        req_ready,
    output logic                        rsp_valid,
    output logic [DW-1:0]               rsp_rdata,
    output logic [NBANK-1:0]            bk_en,
    output logic [NBANK-1:0]            bk_we,
    output logic [NBANK-1:0][ROW_W-1:0] bk_row,
    output logic [NBANK-1:0][BEW-1:0]   bk_be,
    output logic [NBANK-1:0][DW-1:0]    bk_wdata,
    input  logic [NBANK-1:0][DW-1:0]    bk_rdata
);
    logic             dec_hit, dec_bank;
    logic [ROW_W-1:0] dec_row;
    logic             iss_vld, iss_wr, iss_bank;
    logic [ROW_W-1:0] iss_row;

    ilv_addr_decode #(.BASE(BASE), .ROWS(ROWS), .ROW_W(ROW_W)) i_dec (
        .addr (req_addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .row  (dec_row)
    );

    ilv_hazard_fsm #(.ROW_W(ROW_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .dec_hit   (dec_hit),
        .dec_bank  (dec_bank),
        .dec_row   (dec_row),
        .req_ready (req_ready),
        .iss_vld   (iss_vld),
        .iss_wr    (iss_wr),
        .iss_bank  (iss_bank),
        .iss_row   (iss_row)
    );

    ilv_bank_drive #(.ROW_W(ROW_W)) i_drv (
        .iss_vld  (iss_vld),
        .iss_wr   (iss_wr),
        .iss_bank (iss_bank),
        .iss_row  (iss_row),
        .wr_be    (req_be),
        .wr_data  (req_wdata),
        .bk_en    (bk_en),
        .bk_we    (bk_we),
        .bk_row   (bk_row),
        .bk_be    (bk_be),
        .bk_wdata (bk_wdata)
    );

    ilv_rd_return i_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_rd    (iss_vld && !iss_wr),
        .iss_bank  (iss_bank),
        .bk_rdata  (bk_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/ilv_sram_ctrl_chk.sv
module ilv_sram_ctrl_chk #(
    parameter logic [31:0] BASE = 32'h2000_0000,
    parameter int          ROWS = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [1:0]  bk_en,
    input logic [1:0]  bk_we
);
    logic [31:0] off;
    logic        inr;
    logic        rd_iss;

    assign off    = req_addr - BASE;
    assign inr    = off < (32'(ROWS) * 32'd8);
    assign rd_iss = (bk_en != 2'b00) && (bk_we == 2'b00);

    // R3
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);
    // R3
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> bk_en == 2'b00);
    // R3
    stall_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> rd_iss);
    // R3
    no_rd_after_wr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_we[0] |=> !(bk_en[0] && !bk_we[0]));
    // R3
    no_rd_after_wr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_we[1] |=> !(bk_en[1] && !bk_we[1]));
    // R4
    other_bank_go0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && inr && off[2] && $past(bk_we[0])) |-> req_ready);
    // R4
    other_bank_go1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && inr && !off[2] && $past(bk_we[1])) |-> req_ready);
    // R5
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (req_valid && !req_write && inr && $past(bk_we) != 2'b00));
    // R6
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_iss |=> rsp_valid);
    // R6
    no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_iss |=> !rsp_valid);
    // R7
    out_region_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !inr && req_ready) |-> bk_en == 2'b00);
    // R9
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bk_en));
endmodule

bind ilv_sram_ctrl ilv_sram_ctrl_chk #(.BASE(BASE), .ROWS(ROWS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bk_en     (bk_en),
    .bk_we     (bk_we)
);

// File: tb/test_ilv_sram_ctrl.sv
`timescale 1ns/1ps
module test_ilv_sram_ctrl;
    localparam logic [31:0] BASE  = 32'h2000_0000;
    localparam int          ROWS  = 16;
    localparam int          ROW_W = 4;
    localparam int          WORDS = 2 * ROWS;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        req_valid = 1'b0;
    logic                        req_write = 1'b0;
    logic [31:0]                 req_addr = '0;
    logic [3:0]                  req_be = '0;
    logic [31:0]                 req_wdata = '0;
    logic                        req_ready;
    logic                        rsp_valid;
    logic [31:0]                 rsp_rdata;
    logic [1:0]                  bk_en, bk_we;
    logic [1:0][ROW_W-1:0]       bk_row;
    logic [1:0][3:0]             bk_be;
    logic [1:0][31:0]            bk_wdata;
    logic [1:0][31:0]            bk_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] bmem [2][ROWS];
    logic [31:0] refm [WORDS];
    logic [1:0]  wr_last = 2'b00;
    bit          lw_vld = 0;
    bit          lw_bank = 0;

    always #2.5 clk = ~clk;

    ilv_sram_ctrl #(.BASE(BASE), .ROWS(ROWS)) i_ilv_sram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bk_en(bk_en), .bk_we(bk_we), .bk_row(bk_row), .bk_be(bk_be),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    // behavioural bank arrays with registered read data
    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (bk_en[b]) begin
                if (bk_we[b]) begin
                    for (int l = 0; l < 4; l++)
                        if (bk_be[b][l]) bmem[b][bk_row[b]][8*l +: 8] <= bk_wdata[b][8*l +: 8];
                end else begin
                    bk_rdata[b] <= bmem[b][bk_row[b]];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // physical bank rule: no read in the cycle after a write to that bank (R3)
    always @(posedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < 2; b++) begin
                if (bk_en[b] && !bk_we[b])
                    chk(!wr_last[b], "R3", "bank read right after write", 32'(wr_last[b]), 32'd0);
            end
        end
        wr_last = bk_en & bk_we;
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        lw_vld = 0;
    endtask

    task automatic xfer(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] data, input string dtag);
        logic [31:0]      off;
        bit               inr, bnk, exp_st;
        logic [ROW_W-1:0] row;
        int               w, stalls;
        string            tag;
        off    = addr - BASE;
        inr    = off < 32'(WORDS * 4);
        bnk    = off[2];
        row    = off[3 +: ROW_W];
        w      = int'(off[31:2]);
        exp_st = inr && !wr && lw_vld && (lw_bank == bnk);
        tag    = exp_st ? "R3" : ((inr && !wr && lw_vld) ? "R4" : "R5");
        stalls = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = data;
        #1;
        while (!req_ready) begin
            stalls++;
            chk(bk_en == 2'b00, "R3", "bank enabled during stall", 32'(bk_en), 32'd0);
            @(negedge clk);
            #1;
        end
        if (inr) begin
            chk(bk_en == (2'b01 << bnk), "R1", "bank enable", 32'(bk_en), 32'(2'b01 << bnk));
            chk(bk_row[bnk] == row, "R1", "bank row", 32'(bk_row[bnk]), 32'(row));
            chk(bk_we[bnk] == wr, "R1", "write strobe", 32'(bk_we[bnk]), 32'(wr));
        end else begin
            chk(bk_en == 2'b00, "R7", "bank enabled out of window", 32'(bk_en), 32'd0);
        end
        chk(stalls == int'(exp_st), tag, "wait cycles", 32'(stalls), 32'(exp_st));
        @(posedge clk);
        if (inr && wr)
            for (int l = 0; l < 4; l++)
                if (be[l]) refm[w][8*l +: 8] = data[8*l +: 8];
        #1;
        if (inr && !wr) begin
            chk(rsp_valid == 1'b1, "R6", "response strobe", 32'(rsp_valid), 32'd1);
            chk(rsp_rdata == refm[w], dtag, "read data", rsp_rdata, refm[w]);
        end else begin
            chk(rsp_valid == 1'b0, inr ? "R6" : "R7", "spurious response", 32'(rsp_valid), 32'd0);
        end
        lw_vld  = inr && wr;
        lw_bank = bnk;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired, run hung", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready in reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R8", "rsp in reset", 32'(rsp_valid), 32'd0);
        chk(bk_en == 2'b00, "R8", "bank enable in reset", 32'(bk_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && bk_en == 2'b00, "R8",
            "state after reset", {req_ready, rsp_valid, bk_en}, 32'h8);

        // fill every word back to back (write after write, R5)
        for (int w = 0; w < WORDS; w++)
            xfer(1'b1, BASE + 32'(4*w), 4'hF, 32'hA500_0000 ^ (32'(w) * 32'h0101_0101), "R6");
        // read back back to back (read after read, R5)
        for (int w = 0; w < WORDS; w++)
            xfer(1'b0, BASE + 32'(4*w), 4'h0, 32'h0, "R6");

        // pair sweep: every word against offsets 0..3 and all direction pairs
        for (int i = 0; i < WORDS; i++) begin
            for (int d = 0; d < 4; d++) begin
                for (int k = 0; k < 4; k++) begin
                    int j;
                    j = (i + d) % WORDS;
                    idle();
                    xfer(k[1], BASE + 32'(4*i), 4'hF, 32'(i*4096 + d*256 + k*16 + 1), "R6");
                    xfer(k[0], BASE + 32'(4*j), 4'hF, 32'(j*4096 + d*256 + k*16 + 2), "R6");
                end
            end
        end

        // byte lanes (R2), each read lands in the stall path
        for (int be = 0; be < 16; be++) begin
            idle();
            xfer(1'b1, BASE + 32'(4*(be % WORDS)), 4'hF, 32'h1122_3344, "R2");
            xfer(1'b1, BASE + 32'(4*(be % WORDS)), 4'(be), 32'hDEAD_BEEF, "R2");
            xfer(1'b0, BASE + 32'(4*(be % WORDS)), 4'h0, 32'h0, "R2");
        end

        // out of window (R7)
        idle();
        xfer(1'b1, BASE - 32'd4, 4'hF, 32'hBAD0_0001, "R7");
        xfer(1'b1, BASE + 32'(WORDS*4), 4'hF, 32'hBAD0_0002, "R7");
        xfer(1'b1, BASE + 32'(WORDS*4 + 4), 4'hF, 32'hBAD0_0003, "R7");
        xfer(1'b0, BASE + 32'(WORDS*4 + 4), 4'h0, 32'h0, "R7");
        xfer(1'b1, 32'h0000_0000, 4'hF, 32'hBAD0_0004, "R7");
        xfer(1'b0, BASE, 4'h0, 32'h0, "R7");
        for (int w = 0; w < WORDS; w++)
            xfer(1'b0, BASE + 32'(4*w), 4'h0, 32'h0, "R7");
        idle();
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule